// File: doc/BRIEF.md
# Return Address Stack Predictor

This block guesses where a procedure return will land. Fetch tells it, cycle by cycle, whether the instruction at the current PC is a call, a register-indirect jump, or both. On a call it saves the address of the next instruction (PC + 4) in a small circular stack. On a return, which is an indirect jump through the link register, it offers the newest saved address as the next PC and drops that entry.

The prediction is combinational. It appears in the same cycle as the return indication, so the fetch stage can steer its next-PC mux without an extra stage. When the stack runs out of entries, the oldest saved address is overwritten. When it is empty, a return gets no prediction. An indirect jump through any register other than the link register is not a return, so this block ignores it and leaves it to other logic.

Top module: `ret_addr_stack_pred`

## Requirements
- R1: A call (`call_i` high) saves `pc_i + 4`. The next return with no other call in between predicts exactly that value.
- R2: A return (`jr_i` and `jr_link_i` both high) on a non-empty stack drives `pred_valid_o` high and `pred_target_o` to the newest saved address in that same cycle. It then removes that entry.
- R3: Nested calls are returned in last-in, first-out order. After calls at 0x104 and 0x124, the first return predicts 0x128 and the second predicts 0x108.
- R4: A register-indirect jump with `jr_link_i` low gives `pred_valid_o` low and `pred_target_o` zero. It leaves the stack contents and order unchanged.
- R5: When more than DEPTH calls are outstanding, each extra call overwrites the oldest entry, and the held count stays at DEPTH. The next DEPTH returns yield the newest DEPTH addresses, newest first, and the return after them is invalid.
- R6: A return on an empty stack gives `pred_valid_o` low and `pred_target_o` zero. It moves no pointer, so later calls and returns pair up as if it had not happened.
- R7: A call and a return in the same cycle on a non-empty stack predict the old top entry. That entry is then replaced by the call's `pc_i + 4`, and the entries below it are kept.
- R8: A call and a return in the same cycle on an empty stack give an invalid prediction. The call's `pc_i + 4` is still saved.
- R9: Reset empties the stack, so the first return after reset is invalid.
- R10: In a cycle with no return, `pred_valid_o` is low and `pred_target_o` is zero, and the stack is not changed except by a call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Instruction at `pc_i` is a call that writes the link register |
| jr_i | input | 1 | Instruction at `pc_i` is a register-indirect jump |
| jr_link_i | input | 1 | The indirect jump reads the link register (marks a return) |
| pc_i | input | ADDR_W (32) | Address of the instruction being fetched |
| pred_target_o | output | ADDR_W (32) | Predicted return target; zero when not valid |
| pred_valid_o | output | 1 | Prediction is available for this return |

## Verification
The bench compares the outputs, one cycle at a time, against its own bounded stack model. It drives several kinds of call and return sequence, and each one separates a different failure:
- Two nested calls unwound to empty catch a reversed order, a wrong link offset, or a missing empty check.
- More than DEPTH calls followed by a full unwind show whether the oldest entries are overwritten in the right order and whether the count saturates.
- Runs of returns on an empty stack, followed by fresh calls, expose a pointer that moves on underflow.
- Same-cycle call-and-return cases, on a non-empty and on an empty stack, separate replace-top behaviour from push-then-pop or pop-only behaviour.
- Non-link indirect jumps and idle cycles placed between pushes and pops show any disturbance of the stack.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Stack operation applied at the next clock edge.
  typedef enum logic [1:0] {
    RAS_OP_IDLE = 2'd0,
    RAS_OP_PUSH = 2'd1,
    RAS_OP_POP  = 2'd2,
    RAS_OP_SWAP = 2'd3   // pop and push in one cycle: top is replaced
  } ras_op_e;

  // Circular successor of a slot index for a stack of the given depth.
  function automatic int unsigned ras_idx_next(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // Circular predecessor of a slot index for a stack of the given depth.
  function automatic int unsigned ras_idx_prev(int unsigned idx, int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // Occupancy after a push, saturating at the depth.
  function automatic int unsigned ras_cnt_after_push(int unsigned cnt, int unsigned depth);
    return (cnt == depth) ? depth : cnt + 1;
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_req_i,
  output ras_op_e          op_o,
  output logic [IDX_W-1:0] top_idx_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             empty_o
);

  logic [IDX_W-1:0] top_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_eff;
  ras_op_e          op;

  assign empty_o = (cnt_q == '0);
  assign pop_eff = pop_req_i && !empty_o;   // underflow: pop is dropped

  always_comb begin
    unique case ({push_i, pop_eff})
      2'b10:   op = RAS_OP_PUSH;
      2'b01:   op = RAS_OP_POP;
      2'b11:   op = RAS_OP_SWAP;
      default: op = RAS_OP_IDLE;
    endcase
  end

  assign op_o      = op;
  assign top_idx_o = top_q;
  assign wr_idx_o  = (op == RAS_OP_SWAP) ? top_q
                                         : IDX_W'(ras_idx_next(int'(top_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op)
        RAS_OP_PUSH: begin
          top_q <= IDX_W'(ras_idx_next(int'(top_q), DEPTH));
          cnt_q <= CNT_W'(ras_cnt_after_push(int'(cnt_q), DEPTH));
        end
        RAS_OP_POP: begin
          top_q <= IDX_W'(ras_idx_prev(int'(top_q), DEPTH));
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R5

  AST_FULL_PUSH_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_OP_PUSH && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH)); // R5

  AST_UNDERFLOW_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_req_i && !push_i) |=> ($stable(top_q) && empty_o)); // R6

  AST_SWAP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_OP_SWAP) |=> ($stable(top_q) && $stable(cnt_q))); // R7

  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> empty_o); // R9

endmodule

// File: rtl/ras_entry_file.sv
module ras_entry_file #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [ADDR_W-1:0] slot_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_idx_i == IDX_W'(g)) slot_q <= wr_data_i;
    end
    assign slot_view[g] = slot_q;
  end

  assign rd_data_o = slot_view[rd_idx_i];

endmodule

// File: rtl/ret_addr_stack_pred.sv
module ret_addr_stack_pred
  import ras_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              jr_i,
  input  logic              jr_link_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic              pred_valid_o
);

  // Address a call returns to: the instruction after it.
  function automatic logic [ADDR_W-1:0] link_of(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(INSN_BYTES);
  endfunction

  // Named internal events for assertions.
  logic              ret_evt;
  logic              wr_en;
  logic              empty;
  ras_op_e           op;
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] top_data;
  logic [ADDR_W-1:0] link_addr;

  assign ret_evt   = jr_i && jr_link_i;
  assign link_addr = link_of(pc_i);
  assign wr_en     = (op == RAS_OP_PUSH) || (op == RAS_OP_SWAP);

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (call_i),
    .pop_req_i (ret_evt),
    .op_o      (op),
    .top_idx_o (top_idx),
    .wr_idx_o  (wr_idx),
    .empty_o   (empty)
  );

  ras_entry_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (link_addr),
    .rd_idx_i  (top_idx),
    .rd_data_o (top_data)
  );

  assign pred_valid_o  = ret_evt && !empty;
  assign pred_target_o = pred_valid_o ? top_data : '0;

  AST_CALL_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> top_data == $past(link_addr)); // R1

  AST_NONLINK_JUMP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (jr_i && !jr_link_i && !call_i) |=> ($stable(top_idx) && $stable(top_data))); // R4

  AST_NO_RET_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_evt |-> (!pred_valid_o && pred_target_o == '0)); // R10

endmodule

// File: tb/ret_addr_stack_pred_tb.sv
module ret_addr_stack_pred_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;

  typedef struct {
    logic              vld;
    logic [ADDR_W-1:0] tgt;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              call_i = 1'b0;
  logic              jr_i = 1'b0;
  logic              jr_link_i = 1'b0;
  logic [ADDR_W-1:0] pc_i = '0;
  logic [ADDR_W-1:0] pred_target_o;
  logic              pred_valid_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  exp_t              exp_q[$];
  logic [ADDR_W-1:0] mdl[$];

  always #10 clk = ~clk;   // 50 MHz

  ret_addr_stack_pred #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .call_i        (call_i),
    .jr_i          (jr_i),
    .jr_link_i     (jr_link_i),
    .pc_i          (pc_i),
    .pred_target_o (pred_target_o),
    .pred_valid_o  (pred_valid_o)
  );

  // Driver: applies one fetch cycle and queues the expected prediction.
  task automatic step(input logic c, input logic j, input logic l,
                      input logic [ADDR_W-1:0] pc, input string tag);
    exp_t e;
    logic ret;
    @(negedge clk);
    call_i = c; jr_i = j; jr_link_i = l; pc_i = pc;
    ret   = j && l;
    e.vld = ret && (mdl.size() > 0);
    e.tgt = e.vld ? mdl[$] : '0;
    e.tag = tag;
    exp_q.push_back(e);
    if (ret && mdl.size() > 0) void'(mdl.pop_back());
    if (c) mdl.push_back(pc + 32'd4);
    if (mdl.size() > DEPTH) void'(mdl.pop_front());
  endtask

  task automatic do_call(input logic [ADDR_W-1:0] pc, input string tag);
    step(1'b1, 1'b0, 1'b0, pc, tag);
  endtask

  task automatic do_ret(input logic [ADDR_W-1:0] pc, input string tag);
    step(1'b0, 1'b1, 1'b1, pc, tag);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    call_i = 1'b0; jr_i = 1'b0; jr_link_i = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mdl.delete();
  endtask

  // Monitor: compares outputs mid-way between the driving edge and the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (pred_valid_o !== e.vld || pred_target_o !== e.tgt) begin
          n_bad++;
          $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
                   e.tag, pred_valid_o, pred_target_o, e.vld, e.tgt);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: empty after reset
    do_ret(32'h0, "R9 return after reset");

    // R1 R2 R3: nested calls unwind in order
    do_call(32'h104, "R10 call cycle no pred");
    do_call(32'h124, "R10 call cycle no pred");
    do_ret(32'h30C, "R3 inner return 0x128");
    do_ret(32'h12C, "R2 R1 outer return 0x108");
    do_ret(32'h10C, "R6 underflow after unwind");

    // R4: non-link indirect jump ignored
    do_call(32'h200, "R1 call 0x200");
    step(1'b0, 1'b1, 1'b0, 32'h250, "R4 switch jump no pred");
    do_ret(32'h260, "R4 stack intact 0x204");

    // R7: call and return together on non-empty stack
    do_call(32'h300, "R1 call 0x300");
    do_call(32'h310, "R1 call 0x310");
    step(1'b1, 1'b1, 1'b1, 32'h400, "R7 swap predicts 0x314");
    do_ret(32'h410, "R7 replaced top 0x404");
    do_ret(32'h420, "R7 below kept 0x304");
    do_ret(32'h430, "R6 empty again");

    // R8: call and return together on empty stack
    step(1'b1, 1'b1, 1'b1, 32'h500, "R8 swap on empty invalid");
    do_ret(32'h510, "R8 pushed 0x504");

    // R5: overflow overwrites oldest
    for (int i = 0; i < DEPTH + 2; i++) do_call(32'h1000 + 32'(i) * 32'h10, "R5 deep call");
    for (int i = 0; i < DEPTH + 1; i++) do_ret(32'h2000, "R5 deep unwind");

    // R6: repeated underflow moves no pointer
    do_ret(32'h0, "R6 underflow 1");
    do_ret(32'h0, "R6 underflow 2");
    do_ret(32'h0, "R6 underflow 3");
    do_call(32'h600, "R1 call 0x600");
    do_call(32'h610, "R1 call 0x610");
    do_ret(32'h700, "R6 pairing 0x614");
    do_ret(32'h700, "R6 pairing 0x604");
    do_ret(32'h700, "R6 empty after pairing");

    // R10: idle and non-return cycles do not disturb the stack
    do_call(32'h800, "R1 call 0x800");
    step(1'b0, 1'b0, 1'b0, 32'h900, "R10 idle cycle");
    step(1'b0, 1'b0, 1'b1, 32'h904, "R10 link flag alone");
    do_ret(32'h908, "R10 stack intact 0x804");

    // R9: reset in the middle of use
    do_call(32'hA00, "R1 call 0xA00");
    do_call(32'hA10, "R1 call 0xA10");
    apply_reset();
    do_ret(32'h0, "R9 return after mid-run reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule